// File: doc/BRIEF.md
# Frame-locked PWM frequency synthesizer

This block produces a PWM frame rate that is tied to an incoming vertical-sync pulse train. It counts the system-clock cycles between rising vsync edges. From that count it derives a PWM frame period that is a rational fraction of the frame: the PWM rate is the vsync rate times (D+1)/5, and it can be multiplied by four for slow frame rates. The block emits a single-cycle tick at the start of every PWM frame. Each vsync edge also forces a tick and restarts the PWM sequence, so rounding error can never build up beyond a single video frame.

An 8-bit control register holds the setting. It has a 7-bit divide field D and a x4 range bit, and it is written through a plain write-enable port. Setting the range bit is meant for frame rates below about 40 Hz. A new setting takes effect only at a vsync edge. At that edge a sequential divider computes the new period from the length of the frame that has just ended. If vsync stops for longer than a programmable number of cycles, the block raises a lost-sync flag and keeps ticking at the last computed period.

Top module: `frame_pwm_synth`

## Requirements
- R1: After reset, the control register reads 0x10 (range bit 7 = 0, divide field bits 6..0 = 16). `pwm_tick` and `sync_lost` are low until the first vsync edge. At a 60 Hz frame rate this setting gives about 204 Hz PWM.
- R2: A cycle with `cfg_we` high loads `cfg_wdata` into the register, and the value shows on `cfg_rdata` in the next cycle. Bit 7 is the x4 range bit and bits 6..0 are the divide field D.
- R3: Every rising vsync edge produces a `pwm_tick`, which also restarts the PWM frame counter. The tick is registered on the third rising clock edge, counted from the first edge at which `vsync` is sampled high.
- R4: Let P be the number of clocks between two consecutive rising vsync edges. Let M be 4 when bit 7 is set and 1 otherwise. The PWM period is Q = floor(5·P / ((D+1)·M)). Within a steady frame, ticks occur at offsets 0, Q, 2Q, … after the edge tick, until the next edge.
- R5: After reset, the first vsync edge only arms the measurement. Until a period has been computed at the second edge, ticks occur only at vsync edges.
- R6: The setting is sampled at a vsync edge. The period is computed there from the frame that just ended. A register write in the middle of a frame does not change the tick spacing before the next edge.
- R7: A computed period of 0 is raised to 1, which gives a tick every clock. A period of P or more gives only the edge ticks.
- R8: Suppose no rising vsync edge arrives for more than `timeout_lim` clocks after an edge. Then `sync_lost` goes high and ticks continue at the last period with unchanged phase. The next edge clears `sync_lost` in the same cycle as its tick.
- R9: The first edge after a loss restarts the phase but keeps the previous period. It does not compute a new period from the gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Control register write enable |
| cfg_wdata | input | 8 | Control register write data (bit 7 range, bits 6..0 divide) |
| cfg_rdata | output | 8 | Current control register value |
| timeout_lim | input | TO_W | Clocks without a vsync edge before sync is declared lost |
| vsync | input | 1 | Asynchronous vertical-sync input |
| pwm_tick | output | 1 | Single-cycle PWM frame start |
| sync_lost | output | 1 | High while vsync has been absent past the timeout |

## Verification
The bench compares every clock of a steady frame against the tick pattern predicted from the frame length and the setting. An off-by-one in the measured length or the divider would show up as drifted tick offsets. So would a missing edge restart, or a wrong x4 scaling. Directed cases cover settings that clamp the period to 1, where a design without the clamp would stop ticking or hang. They also cover settings whose period exceeds the frame, where only edge ticks may appear. A register write in mid-frame and the first frames after reset are exercised too, and a design that applied settings early or ticked on a stale period would show extra ticks there. A long vsync gap checks that ticking continues and the flag rises. It also checks that the recovery edge does not take a period from the gap, which would make the ticks vanish.

// File: rtl/fps_pkg.sv
// Shared constants, the control-register type and the denominator helper
// for the frame-locked PWM synthesizer. Assumes a 7-bit divide field.
package fps_pkg;
    localparam int DIV_W = 7;
    localparam int CFG_W = DIV_W + 1;
    localparam int DEN_W = DIV_W + 3;
    localparam logic [CFG_W-1:0] CFG_RESET = 8'h10;

    typedef struct packed {
        logic             range_x4;
        logic [DIV_W-1:0] div;
    } fps_cfg_t;

    // (div+1) scaled by four when the range bit is set
    function automatic logic [DEN_W-1:0] fps_denominator(fps_cfg_t c);
        logic [DEN_W-1:0] base;
        base = DEN_W'(c.div) + DEN_W'(1);
        return c.range_x4 ? (base << 2) : base;
    endfunction
endpackage

// File: rtl/fps_vsync_meter.sv
// Synchronises vsync, detects rising edges and measures the clock count
// between consecutive edges. Assumes vsync is asynchronous and high for at
// least two clocks. The count saturates and a saturated count is not valid.
module fps_vsync_meter #(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vsync,
    output logic             rise,
    output logic             armed,
    output logic             meas_ok,
    output logic [CNT_W-1:0] meas
);
    logic [1:0]       sync_q;
    logic             prev_q;
    logic [CNT_W-1:0] cnt_q;
    logic             armed_q;
    logic             sat;

    // two-flop synchroniser plus edge history
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= 2'b00;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[0], vsync};
            prev_q <= sync_q[1];
        end
    end

    assign rise = sync_q[1] & ~prev_q;

    // cycle counter cleared on each edge, saturating when vsync stops
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (rise) begin
            cnt_q <= '0;
        end else if (cnt_q != '1) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    // remembers that one edge has been seen since reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else if (rise) begin
            armed_q <= 1'b1;
        end
    end

    assign sat     = (cnt_q == '1);
    assign meas    = sat ? cnt_q : cnt_q + CNT_W'(1);
    assign meas_ok = armed_q & ~sat;
    assign armed   = armed_q;
endmodule

// File: rtl/fps_divider.sv
// Restoring unsigned divider: one quotient bit per clock, NUM_W clocks
// from start to the done pulse. A start while busy restarts the division.
// Assumes den is non-zero.
module fps_divider #(
    parameter int NUM_W = 23,
    parameter int DEN_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             done,
    output logic [NUM_W-1:0] quo
);
    localparam int CW = $clog2(NUM_W + 1);

    logic             busy_q;
    logic             done_q;
    logic [CW-1:0]    step_q;
    logic [NUM_W-1:0] quo_q;
    logic [DEN_W-1:0] rem_q;
    logic [DEN_W-1:0] den_q;
    logic [DEN_W:0]   trial;
    logic [DEN_W:0]   diff;
    logic             fits;
    logic [DEN_W:0]   rem_nxt;

    // trial subtraction for the next quotient bit
    always_comb begin
        trial   = {rem_q, quo_q[NUM_W-1]};
        fits    = (trial >= {1'b0, den_q});
        diff    = trial - {1'b0, den_q};
        rem_nxt = fits ? diff : trial;
    end

    // iteration state and result shift register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            step_q <= '0;
            quo_q  <= '0;
            rem_q  <= '0;
            den_q  <= '0;
        end else if (start) begin
            busy_q <= 1'b1;
            done_q <= 1'b0;
            step_q <= CW'(NUM_W);
            quo_q  <= num;
            rem_q  <= '0;
            den_q  <= den;
        end else if (busy_q) begin
            rem_q  <= DEN_W'(rem_nxt);
            quo_q  <= {quo_q[NUM_W-2:0], fits};
            step_q <= step_q - CW'(1);
            if (step_q == CW'(1)) begin
                busy_q <= 1'b0;
                done_q <= 1'b1;
            end else begin
                done_q <= 1'b0;
            end
        end else begin
            done_q <= 1'b0;
        end
    end

    assign done = done_q;
    assign quo  = quo_q;
endmodule

// File: rtl/fps_tick_gen.sv
// Holds the PWM period and produces frame ticks: one on every vsync edge,
// plus one each time the period counter wraps. Also tracks the time since
// the last edge and flags lost sync. Assumes load_val is a raw quotient.
module fps_tick_gen #(
    parameter int PER_W = 23,
    parameter int TO_W  = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise,
    input  logic             armed,
    input  logic             load,
    input  logic [PER_W-1:0] load_val,
    input  logic [TO_W-1:0]  timeout_lim,
    output logic             pwm_tick,
    output logic             sync_lost,
    output logic             per_vld,
    output logic [PER_W-1:0] per_val
);
    logic [PER_W-1:0] per_q;
    logic             per_vld_q;
    logic [PER_W-1:0] pcnt_q;
    logic             tick_q;
    logic [TO_W-1:0]  tcnt_q;
    logic             lost_q;

    // period register, clamped to at least one clock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_q     <= '0;
            per_vld_q <= 1'b0;
        end else if (load) begin
            per_q     <= (load_val == '0) ? PER_W'(1) : load_val;
            per_vld_q <= 1'b1;
        end
    end

    // frame counter: restart on edge, wrap on period
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_q <= 1'b0;
            pcnt_q <= '0;
        end else if (rise) begin
            tick_q <= 1'b1;
            pcnt_q <= '0;
        end else if (per_vld_q && (pcnt_q >= per_q - PER_W'(1))) begin
            tick_q <= 1'b1;
            pcnt_q <= '0;
        end else begin
            tick_q <= 1'b0;
            if (pcnt_q != '1) begin
                pcnt_q <= pcnt_q + PER_W'(1);
            end
        end
    end

    // lost-sync watchdog, running once the first edge has been seen
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tcnt_q <= '0;
            lost_q <= 1'b0;
        end else if (rise) begin
            tcnt_q <= '0;
            lost_q <= 1'b0;
        end else if (armed) begin
            if (tcnt_q >= timeout_lim) begin
                lost_q <= 1'b1;
            end else begin
                tcnt_q <= tcnt_q + TO_W'(1);
            end
        end
    end

    assign pwm_tick  = tick_q;
    assign sync_lost = lost_q;
    assign per_vld   = per_vld_q;
    assign per_val   = per_q;
endmodule

// File: rtl/frame_pwm_synth.sv
// Top level of the frame-locked PWM synthesizer. Holds the control
// register, and at each valid vsync edge divides 5x the measured frame
// length by the scaled divide setting. Assumes a synchronous active-low
// reset and a frame longer than the divider latency (CNT_W+3 clocks).
module frame_pwm_synth
    import fps_pkg::*;
#(
    parameter int CNT_W = 20,
    parameter int TO_W  = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [7:0]       cfg_wdata,
    output logic [7:0]       cfg_rdata,
    input  logic [TO_W-1:0]  timeout_lim,
    input  logic             vsync,
    output logic             pwm_tick,
    output logic             sync_lost
);
    localparam int NUM_W = CNT_W + 3;
    localparam int PER_W = NUM_W;

    fps_cfg_t         cfg_q;
    logic             vs_rise;
    logic             vs_armed;
    logic             meas_ok;
    logic [CNT_W-1:0] meas;
    logic [NUM_W-1:0] num;
    logic [DEN_W-1:0] den;
    logic             div_start;
    logic             div_done;
    logic [NUM_W-1:0] div_quo;
    logic             tick_per_vld;
    logic [PER_W-1:0] tick_per_val;

    // control register with reset value 0x10
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= fps_cfg_t'(CFG_RESET);
        end else if (cfg_we) begin
            cfg_q <= fps_cfg_t'(cfg_wdata);
        end
    end

    assign cfg_rdata = cfg_q;

    fps_vsync_meter #(.CNT_W(CNT_W)) u_meter (
        .clk     (clk),
        .rst_n   (rst_n),
        .vsync   (vsync),
        .rise    (vs_rise),
        .armed   (vs_armed),
        .meas_ok (meas_ok),
        .meas    (meas)
    );

    // 5 * measured length, denominator from the setting sampled at the edge
    assign num       = ({3'b000, meas} << 2) + {3'b000, meas};
    assign den       = fps_denominator(cfg_q);
    assign div_start = vs_rise & meas_ok & ~sync_lost;

    fps_divider #(.NUM_W(NUM_W), .DEN_W(DEN_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .start (div_start),
        .num   (num),
        .den   (den),
        .done  (div_done),
        .quo   (div_quo)
    );

    fps_tick_gen #(.PER_W(PER_W), .TO_W(TO_W)) u_tick (
        .clk         (clk),
        .rst_n       (rst_n),
        .rise        (vs_rise),
        .armed       (vs_armed),
        .load        (div_done),
        .load_val    (div_quo),
        .timeout_lim (timeout_lim),
        .pwm_tick    (pwm_tick),
        .sync_lost   (sync_lost),
        .per_vld     (tick_per_vld),
        .per_val     (tick_per_val)
    );
endmodule

// File: rtl/fps_checker.sv
// Temporal checks on the synthesizer's edge handling, register port and
// period state. Attached to every frame_pwm_synth instance by bind.
module fps_checker #(
    parameter int PER_W = 23
) (
    input logic             clk,
    input logic             rst_n,
    input logic             vs_rise,
    input logic             pwm_tick,
    input logic             sync_lost,
    input logic             cfg_we,
    input logic [7:0]       cfg_wdata,
    input logic [7:0]       cfg_rdata,
    input logic             per_vld,
    input logic [PER_W-1:0] per_val
);
    assert_cfg_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (cfg_rdata == $past(cfg_wdata)));

    assert_tick_on_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
        vs_rise |=> pwm_tick);

    assert_tick_needs_period_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_tick && !$past(vs_rise)) |-> $past(per_vld));

    assert_period_floor_R7: assert property (@(posedge clk) disable iff (!rst_n)
        per_vld |-> (per_val != '0));

    assert_lost_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
        vs_rise |=> !sync_lost);

    assert_lost_not_on_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_lost) |-> !$past(vs_rise));
endmodule

bind frame_pwm_synth fps_checker #(.PER_W(NUM_W)) u_fps_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .vs_rise   (vs_rise),
    .pwm_tick  (pwm_tick),
    .sync_lost (sync_lost),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .per_vld   (tick_per_vld),
    .per_val   (tick_per_val)
);

// File: tb/tb_frame_pwm_synth.sv
module tb_frame_pwm_synth;
    localparam int CNT_W = 20;
    localparam int TO_W  = 20;
    localparam int TMO   = 3000;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cfg_we = 1'b0;
    logic [7:0]      cfg_wdata = 8'h00;
    logic [7:0]      cfg_rdata;
    logic [TO_W-1:0] timeout_lim = TO_W'(TMO);
    logic            vsync = 1'b0;
    logic            pwm_tick;
    logic            sync_lost;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    frame_pwm_synth #(.CNT_W(CNT_W), .TO_W(TO_W)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we      (cfg_we),
        .cfg_wdata   (cfg_wdata),
        .cfg_rdata   (cfg_rdata),
        .timeout_lim (timeout_lim),
        .vsync       (vsync),
        .pwm_tick    (pwm_tick),
        .sync_lost   (sync_lost)
    );

    // expected period from R4 with the clamp of R7
    function automatic int exp_q(int p, logic [7:0] c);
        int den;
        int q;
        den = (int'(c[6:0]) + 1) * (c[7] ? 4 : 1);
        q = (5 * p) / den;
        if (q < 1) q = 1;
        return q;
    endfunction

    task automatic check(bit ok, string req, string what, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic wr_cfg(logic [7:0] v);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
        check(cfg_rdata == v, "R2", "cfg readback", int'(cfg_rdata), int'(v));
    endtask

    // One frame of p clocks. With pulse, vsync rises at i=0; the tick is due
    // at i=3 (R3). Offsets i<3 belong to the previous frame (o_base + i).
    // q==0 means only the edge tick is expected.
    task automatic run_frame(int p, int q, bit pulse, int o_base, bit chk_head,
                             bit chk_body, bit lost_zero, string req,
                             bit mid_we, logic [7:0] mid_val);
        int bad_i = -1;
        int bad_act = 0;
        int bad_exp = 0;
        int lost_bad = -1;
        for (int i = 0; i < p; i++) begin
            int o;
            bit e;
            bit chk;
            @(negedge clk);
            if (pulse) o = (i >= 3) ? i - 3 : o_base + i;
            else       o = o_base + i;
            e = (q == 0) ? (o == 0) : ((o % q) == 0);
            chk = (pulse && i < 3) ? chk_head : chk_body;
            if (chk && (pwm_tick !== e) && bad_i < 0) begin
                bad_i = i;
                bad_act = int'(pwm_tick);
                bad_exp = int'(e);
            end
            if (lost_zero && pulse && i >= 3 && sync_lost !== 1'b0 && lost_bad < 0)
                lost_bad = i;
            vsync = pulse && (i < 4);
            cfg_we = mid_we && (i == p / 2);
            if (mid_we && (i == p / 2)) cfg_wdata = mid_val;
        end
        if (chk_head || chk_body)
            check(bad_i < 0, req, $sformatf("tick pattern at frame cycle %0d (p=%0d q=%0d)", bad_i, p, q),
                  bad_act, bad_exp);
        if (lost_zero)
            check(lost_bad < 0, "R8", $sformatf("sync_lost in frame at cycle %0d", lost_bad),
                  lost_bad < 0 ? 0 : 1, 0);
    endtask

    // settled scenario: apply cfg, let two frames settle, check frames 3 and 4
    task automatic scenario(int p, logic [7:0] c, string req, bit mid_we, logic [7:0] mid_val);
        int q;
        q = exp_q(p, c);
        wr_cfg(c);
        run_frame(p, q, 1, 0, 0, 0, 0, req, 0, 8'h00);
        run_frame(p, q, 1, 0, 0, 0, 0, req, 0, 8'h00);
        run_frame(p, q, 1, p - 3, 0, 1, 1, req, 0, 8'h00);
        run_frame(p, q, 1, p - 3, 1, 1, 1, mid_we ? "R6" : req, mid_we, mid_val);
    endtask

    initial begin
        int seed;
        int q;
        seed = $urandom(32'd7741);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        // R1: reset state
        check(pwm_tick == 1'b0, "R1", "tick after reset", int'(pwm_tick), 0);
        check(sync_lost == 1'b0, "R1", "sync_lost after reset", int'(sync_lost), 0);
        check(cfg_rdata == 8'h10, "R1", "reset register value", int'(cfg_rdata), 16);

        // R5: first edge only arms; R1: default setting gives 5P/17
        run_frame(1000, 0, 1, 0, 0, 1, 1, "R5", 0, 8'h00);
        q = exp_q(1000, 8'h10);
        check(q == 294, "R1", "default period", q, 294);
        run_frame(1000, q, 1, 0, 0, 1, 1, "R1", 0, 8'h00);
        run_frame(1000, q, 1, 997, 1, 1, 1, "R4", 0, 8'h00);

        // R4/R6: random settings and frame lengths, mid-frame write
        for (int k = 0; k < 12; k++) begin
            int p;
            logic [7:0] c;
            logic [7:0] m;
            p = 600 + int'($urandom % 900);
            c = 8'($urandom);
            m = 8'($urandom);
            scenario(p, c, "R4", 1, m);
        end

        // directed corners
        scenario(1000, 8'h84, "R4", 0, 8'h00);   // x4 range, D=4
        scenario(800, 8'h00, "R7", 0, 8'h00);    // period above frame
        scenario(60, 8'hFF, "R7", 0, 8'h00);     // clamp to 1
        scenario(700, 8'h7F, "R4", 0, 8'h00);    // largest divide, x1

        // R8/R9: vsync loss and recovery
        q = exp_q(900, 8'h22);
        scenario(900, 8'h22, "R4", 0, 8'h00);
        check(sync_lost == 1'b0, "R8", "no loss before gap", int'(sync_lost), 0);
        run_frame(TMO + 300, q, 0, 900 - 3, 0, 1, 0, "R8", 0, 8'h00);
        check(sync_lost == 1'b1, "R8", "loss after gap", int'(sync_lost), 1);
        run_frame(900, q, 1, 0, 0, 1, 1, "R9", 0, 8'h00);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL R3 watchdog: actual %0d cycles expected completion earlier", 200000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule